// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a selectable prescaled clock, controlled through an 8-bit control/status register. A mode bit selects one of two uses. In interval mode, a counter overflow sets a sticky flag that raises an interrupt request. In watchdog mode, an overflow emits a fixed-length pulse on an external overflow line, which can be used to reset the system.

Stray writes must not upset the timer. For that reason, both registers accept writes only as 16-bit accesses, and the upper byte of each write must carry a register-specific key. Software reads both registers as bytes over a simple register bus. Each access completes one cycle after it is presented. The interval flag uses a read-then-clear handshake: a write of 0 clears it only after software has seen it set.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, a byte read of the control/status register returns 0x18 and a byte read of the counter returns 0x00. `irq_o` and `wdt_ovf_o` are low.
- R2: A write to the control/status register (`addr_i`=0) takes effect only when `word_i`=1 and `wdata_i[15:8]`=0xA5. Any other write leaves the register unchanged. The register layout is: flag in bit 7, mode in bit 6 (0 = interval, 1 = watchdog), enable in bit 5, clock select in bits 2:0.
- R3: A write to the counter (`addr_i`=1) takes effect only when `word_i`=1 and `wdata_i[15:8]`=0x5A. The counter then loads `wdata_i[7:0]`.
- R4: Every access raises `ready_o` in the following cycle. A byte read (`word_i`=0) returns the addressed register on `rdata_o`. A word read returns 0x00.
- R5: Bits 4 and 3 of the control/status register always read as 1, whatever is written to them.
- R6: The clock select codes 0 to 7 divide the input clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. The prescaler restarts whenever the timer is disabled. If the enable bit is set at clock edge E0, the counter has advanced by floor(k/d) at edge Ek, where d is the divisor. The counter does not advance while the timer is disabled.
- R7: The counter wraps from 0xFF to 0x00 and keeps counting.
- R8: An overflow in interval mode sets the flag. `irq_o` is high while the flag is 1 and the mode bit is 0.
- R9: Writing 0 to the flag clears it only if a byte read of the control/status register has returned the flag as 1 since the flag was last cleared. Writing 1 to the flag has no effect, and a word read does not enable the clear.
- R10: An overflow in watchdog mode never sets the flag. Instead it drives `wdt_ovf_o` high for exactly 128 input clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = control/status, 1 = counter |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| wdata_i | input | 16 | Write data: key in the upper byte, value in the lower byte |
| rdata_o | output | 8 | Read data, valid with ready_o |
| ready_o | output | 1 | Access completed, one cycle after req_i |
| irq_o | output | 1 | Interval overflow interrupt request |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
The hardest condition to reach from the ports is counter arrival at 0xFF under a slow divisor, with the flag handshake in a particular state.

The stimulus handles this in three ways:
- It preloads the counter through the keyed write, so an overflow is only a few ticks away.
- It runs the timer for a random number of cycles, scaled to up to three divisor periods of the chosen clock select code.
- It stops the timer with a keyed write, so the count can be read back as a fixed value.

Directed sequences then order a word read, a write of 1 and a write of 0 around a set flag, so that each path of the clear handshake is exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W    = 8;
  localparam int CKS_W    = 3;
  localparam int NUM_CKS  = 1 << CKS_W;

  // csr bit positions
  localparam int FLAG_B = 7;
  localparam int MODE_B = 6;
  localparam int EN_B   = 5;

  localparam logic [7:0] CSR_KEY = 8'hA5;
  localparam logic [7:0] CNT_KEY = 8'h5A;

  function automatic int div_shift(input int code);
    case (code)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 6;
      5: return 8;
      6: return 10;
      default: return 12;
    endcase
  endfunction

  localparam int PRESC_W = div_shift(NUM_CKS - 1);
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CKS_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [NUM_CKS-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (!en_i) presc_q <= '0;
    else            presc_q <= presc_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CKS; g++) begin : g_tap
    localparam int SH = div_shift(g);
    if (SH == 0) begin : g_full
      assign tap[g] = 1'b1;
    end else begin : g_div
      assign tap[g] = &presc_q[SH-1:0];
    end
  end

  assign tick_o = en_i & tap[sel_i];
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rem_q <= '0;
    else if (trig_i)          rem_q <= W'(LEN);
    else if (rem_q != '0)     rem_q <= rem_q - 1'b1;
  end

  assign pulse_o = (rem_q != '0);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic             word_i,
  input  logic [15:0]      wdata_i,
  input  logic             tick_i,
  output logic             ovf_o,
  output logic             flag_o,
  output logic             mode_o,
  output logic             en_o,
  output logic [CKS_W-1:0] cks_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       rdata_o,
  output logic             ready_o
);
  logic             flag_q, mode_q, en_q, armed_q;
  logic [CKS_W-1:0] cks_q;
  logic [CNT_W-1:0] cnt_q;
  logic             csr_wr, cnt_wr, csr_rd_byte, clr_flag, ovf;
  logic [7:0]       csr_val;

  assign csr_wr      = req_i & we_i & ~addr_i & word_i & (wdata_i[15:8] == CSR_KEY);
  assign cnt_wr      = req_i & we_i &  addr_i & word_i & (wdata_i[15:8] == CNT_KEY);
  assign csr_rd_byte = req_i & ~we_i & ~addr_i & ~word_i;
  assign clr_flag    = csr_wr & ~wdata_i[FLAG_B] & armed_q;
  assign ovf         = tick_i & (cnt_q == '1) & ~cnt_wr;
  assign csr_val     = {flag_q, mode_q, en_q, 2'b11, cks_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wdata_i[CNT_W-1:0];
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      cks_q  <= '0;
    end else if (csr_wr) begin
      mode_q <= wdata_i[MODE_B];
      en_q   <= wdata_i[EN_B];
      cks_q  <= wdata_i[CKS_W-1:0];
    end
  end

  // set beats clear when both land on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (ovf && !mode_q)   flag_q <= 1'b1;
    else if (clr_flag)         flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    armed_q <= 1'b0;
    else if (clr_flag)              armed_q <= 1'b0;
    else if (csr_rd_byte && flag_q) armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= req_i;
      if (req_i && !we_i && !word_i) rdata_o <= addr_i ? 8'(cnt_q) : csr_val;
      else                           rdata_o <= '0;
    end
  end

  assign ovf_o  = ovf;
  assign flag_o = flag_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign cks_o  = cks_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic        word_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  rdata_o,
  output logic        ready_o,
  output logic        irq_o,
  output logic        wdt_ovf_o
);
  logic             tick, ovf, flag, mode, en;
  logic [CKS_W-1:0] cks;
  logic [CNT_W-1:0] cnt;

  wdt_prescaler u_presc (
    .clk_i, .rst_ni, .en_i(en), .sel_i(cks), .tick_o(tick)
  );

  wdt_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .word_i, .wdata_i,
    .tick_i(tick), .ovf_o(ovf), .flag_o(flag), .mode_o(mode), .en_o(en),
    .cks_o(cks), .cnt_o(cnt), .rdata_o, .ready_o
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .trig_i(ovf & mode), .pulse_o(wdt_ovf_o)
  );

  assign irq_o = flag & ~mode;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int PULSE_LEN = 128
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        addr_i,
  input logic        word_i,
  input logic [15:0] wdata_i,
  input logic        ready_o,
  input logic        wdt_ovf_o,
  input logic        flag,
  input logic        mode,
  input logic        en,
  input logic [2:0]  cks,
  input logic [7:0]  cnt
);
  localparam int HW = $clog2(PULSE_LEN + 1) + 1;
  logic [HW-1:0] hi_cnt;
  logic csr_key_wr, cnt_key_wr;

  assign csr_key_wr = req_i & we_i & ~addr_i & word_i & (wdata_i[15:8] == 8'hA5);
  assign cnt_key_wr = req_i & we_i &  addr_i & word_i & (wdata_i[15:8] == 8'h5A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (wdt_ovf_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  AST_READY_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == $past(req_i)); // R4

  AST_CTRL_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode, en, cks}) |-> $past(csr_key_wr)); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt) && !$past(cnt_key_wr)) |-> (cnt == $past(cnt) + 8'd1 && $past(en))); // R7

  AST_FLAG_CLEAR_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(csr_key_wr && !wdata_i[7])); // R9

  AST_FLAG_NOT_WDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> !$past(mode)); // R10

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_ovf_o) |-> hi_cnt == HW'(PULSE_LEN)); // R10

  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= HW'(PULSE_LEN)); // R10
endmodule

bind keyed_wdt wdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .word_i(word_i), .wdata_i(wdata_i), .ready_o(ready_o), .wdt_ovf_o(wdt_ovf_o),
  .flag(flag), .mode(mode), .en(en), .cks(cks), .cnt(cnt)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, addr_i = 1'b0, word_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ready_o, irq_o, wdt_ovf_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [7:0] rd;

  keyed_wdt u_keyed_wdt (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired: act=%0d exp<=%0d", cycles, MAX_CYCLES);
      report();
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge; one rising edge accepts the access
  task automatic acc(logic w, logic a, logic wd, logic [15:0] d, output logic [7:0] r);
    req_i = 1'b1; we_i = w; addr_i = a; word_i = wd; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    r = rdata_o;
    check("R4 ready", 16'(ready_o), 16'd1);
  endtask

  task automatic rd_csr(output logic [7:0] r);  acc(1'b0, 1'b0, 1'b0, 16'h0, r); endtask
  task automatic rd_cnt(output logic [7:0] r);  acc(1'b0, 1'b1, 1'b0, 16'h0, r); endtask
  task automatic wr_csr(logic [7:0] v);
    logic [7:0] t; acc(1'b1, 1'b0, 1'b1, {8'hA5, v}, t);
  endtask
  task automatic wr_cnt(logic [7:0] v);
    logic [7:0] t; acc(1'b1, 1'b1, 1'b1, {8'h5A, v}, t);
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk_i); endtask

  function automatic int div_sh(int code);
    case (code)
      0: return 0; 1: return 2; 2: return 4; 3: return 5;
      4: return 6; 5: return 8; 6: return 10; default: return 12;
    endcase
  endfunction

  function automatic logic [7:0] csr_exp(logic f, logic m, logic e, logic [2:0] c);
    return {f, m, e, 2'b11, c};
  endfunction

  initial begin
    logic [7:0] t;
    int hi;
    void'($urandom(32'd20240611));
    idle(2);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset
    check("R1 irq", 16'(irq_o), 16'd0);
    check("R1 wdt_ovf", 16'(wdt_ovf_o), 16'd0);
    rd_csr(t); check("R1 csr", 16'(t), 16'h18);
    rd_cnt(t); check("R1 cnt", 16'(t), 16'h00);

    // R2 wrong key / byte writes ignored
    acc(1'b1, 1'b0, 1'b1, 16'h5A27, t);
    rd_csr(t); check("R2 wrong key", 16'(t), 16'h18);
    acc(1'b1, 1'b0, 1'b0, 16'hA527, t);
    rd_csr(t); check("R2 byte write", 16'(t), 16'h18);

    // R3 counter key
    acc(1'b1, 1'b1, 1'b1, 16'hA533, t);
    rd_cnt(t); check("R3 wrong key", 16'(t), 16'h00);
    wr_cnt(8'h33);
    rd_cnt(t); check("R3 keyed load", 16'(t), 16'h33);
    acc(1'b0, 1'b1, 1'b1, 16'h0, t); check("R4 word read", 16'(t), 16'h00);

    // R5 reserved ones
    wr_csr(8'h07);
    rd_csr(t); check("R5 reserved", 16'(t), 16'h1F);

    // R6 divide by one
    wr_cnt(8'h10); wr_csr(8'h20); idle(9); wr_csr(8'h00);
    rd_cnt(t); check("R6 div1 count", 16'(t), 16'h1A);
    idle(20);
    rd_cnt(t); check("R6 disabled hold", 16'(t), 16'h1A);

    // R7 / R8 overflow in interval mode
    wr_cnt(8'hFE); wr_csr(8'h20); idle(5); wr_csr(8'h00);
    rd_cnt(t); check("R7 wrap", 16'(t), 16'h04);
    check("R8 irq", 16'(irq_o), 16'd1);

    // R9 handshake
    acc(1'b0, 1'b0, 1'b1, 16'h0, t); check("R4 word csr read", 16'(t), 16'h00);
    wr_csr(8'h00);
    rd_csr(t); check("R9 no clear unarmed", 16'(t), 16'h98);
    wr_csr(8'h80);
    rd_csr(t); check("R9 write one", 16'(t), 16'h98);
    wr_csr(8'h00);
    rd_csr(t); check("R9 cleared", 16'(t), 16'h18);
    check("R8 irq low", 16'(irq_o), 16'd0);

    // R10 watchdog pulse
    wr_cnt(8'hFE); wr_csr(8'h60);
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (wdt_ovf_o) hi++;
    end
    check("R10 pulse width", 16'(hi), 16'd128);
    rd_csr(t); check("R10 no flag", 16'(t), 16'h78);
    check("R10 no irq", 16'(irq_o), 16'd0);
    wr_csr(8'h00);

    // R6 / R7 / R8 random
    for (int it = 0; it < 40; it++) begin
      int code, sh, n, ticks, total;
      logic [7:0] st;
      logic f;
      code  = $urandom % 8;
      sh    = div_sh(code);
      n     = $urandom % (3 << sh);
      st    = 8'($urandom);
      ticks = (n + 1) >> sh;
      total = int'(st) + ticks;
      f     = (total > 255);
      wr_cnt(st); wr_csr(8'h20 | 8'(code)); idle(n); wr_csr(8'(code));
      rd_cnt(t); check("R6 random count", 16'(t), 16'(total & 255));
      check("R8 random irq", 16'(irq_o), 16'(f));
      rd_csr(t); check("R8 random csr", 16'(t), 16'(csr_exp(f, 1'b0, 1'b0, 3'(code))));
      wr_csr(8'(code));
      check("R9 random clear", 16'(irq_o), 16'd0);
    end

    report();
  end
endmodule